// File: doc/BRIEF.md
# Bit-serial 9/7 wavelet low-pass analysis filter

This block works out one output of the nine-tap low-pass analysis filter of the 9/7 wavelet without using any multiplier. Signed 8-bit samples are accepted one at a time through a valid/ready handshake. Each accepted sample is captured in an input register and then pushed into a nine-deep delay line. Because the filter is symmetric, tap pairs that share a coefficient are added before anything else, which leaves five 9-bit terms.

The five coefficients are the 9/7 low-pass values scaled by 128 and rounded to integers. They are held as fixed 8-bit two's-complement patterns. An adder array built from these patterns forms one partial sum for each coefficient bit: the sum of the terms whose coefficient has a 1 in that bit. A multiplexer hands these partial sums to an accumulator one bit per cycle, least significant bit first. On each step the accumulator shifts its running sum right by one and adds the new partial sum. The sign bit's partial sum is negated before it is added.

After the eighth step the exact dot product is presented with a one-cycle valid pulse. Decimation and the high-pass branch are left to the blocks around this one.

Top module: `nd97_lowpass`

## Requirements
- R1: After reset `smp_ready` is 1, `flt_valid` is 0 and `flt_data` is 0. A sample is taken only in a cycle where `smp_valid` and `smp_ready` are both 1.
- R2: Each accepted sample goes into the input register and then becomes the newest entry of a nine-sample window. Window position 0 is the newest sample and position 8 is the oldest.
- R3: The filter uses five terms: the middle sample (position 4) and the symmetric sums of positions 3+5, 2+6, 1+7 and 0+8.
- R4: The five terms are weighted by 77, 34, -10, -2 and 3 respectively. `flt_data` is the exact signed sum of these products, in two's complement.
- R5: `flt_valid` is high for exactly one cycle. It rises 9 clock edges after the edge that accepts the sample.
- R6: From the accepting edge until after the valid pulse, `smp_ready` is 0. Any `smp_valid` and `smp_data` presented during that time are ignored and do not enter the window.
- R7: Coefficient bit 7 has weight -128. Inputs at full negative and full positive scale give exact results: nine samples of -128 give -16256, and nine samples of 127 give 16129.
- R8: If the five terms equal 1, 2, 3, 4 and 5, the output is 122.
- R9: A synchronous active-low reset applied part-way through a computation clears the window and the accumulator. No valid pulse follows.
- R10: `flt_data` holds its last result for as long as the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample is offered on `smp_data` |
| smp_data | input | 8 | Signed input sample |
| smp_ready | output | 1 | The block can accept a sample |
| flt_valid | output | 1 | One-cycle pulse: `flt_data` holds a new result |
| flt_data | output | 20 | Signed filter result |

## Verification
The bench builds the block with its default parameters: 8-bit samples and 8-bit coefficients. With these settings every value an input sample can take fits in one pass of a few thousand cycles. The bench streams all 256 input values through the window, then sends a unit impulse that shows each coefficient in its place. It adds a long pseudo-random stream and windows held at full negative and full positive scale. Each output is checked against an integer dot product worked out in the bench. It also drives samples while the block is busy, and resets it part-way through a computation.

// File: rtl/nd97_pkg.sv
// Shared constants and types for the bit-serial 9/7 low-pass filter.
// Assumes a symmetric nine-tap kernel, which gives five distinct weights.
package nd97_pkg;
    localparam int NUM_TAPS  = 9;
    localparam int NUM_TERMS = (NUM_TAPS + 1) / 2;
    localparam int MID_TAP   = NUM_TERMS - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/nd97_tapline.sv
// Input register, nine-deep sample window and symmetric pre-adders.
// Position 0 holds the newest sample. A captured sample enters the
// window one cycle later, when shift_en is high.
module nd97_tapline
    import nd97_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = DATA_W + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_en,
    input  logic                              shift_en,
    input  logic [DATA_W-1:0]                 smp_data,
    output logic [NUM_TERMS-1:0][PRE_W-1:0]   terms
);
    logic [DATA_W-1:0]                in_reg;
    logic [NUM_TAPS-1:0][DATA_W-1:0]  taps;

    // Capture the accepted sample in the input register.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_reg <= '0;
        else if (cap_en) in_reg <= smp_data;
    end

    // Push the captured sample into the window.
    always_ff @(posedge clk) begin
        if (!rst_n)        taps <= '0;
        else if (shift_en) taps <= {taps[NUM_TAPS-2:0], in_reg};
    end

    // Middle tap alone, then each pair of taps that shares a weight.
    assign terms[0] = {taps[MID_TAP][DATA_W-1], taps[MID_TAP]};
    for (genvar i = 1; i < NUM_TERMS; i++) begin : g_pair
        assign terms[i] = {taps[MID_TAP-i][DATA_W-1], taps[MID_TAP-i]}
                        + {taps[MID_TAP+i][DATA_W-1], taps[MID_TAP+i]};
    end
endmodule

// File: rtl/nd97_bitsum.sv
// Fixed adder array. For each coefficient bit it sums the terms whose
// coefficient has a 1 in that bit. Assumes PS_W leaves room for all
// five terms.
module nd97_bitsum
    import nd97_pkg::*;
#(
    parameter int PRE_W  = 9,
    parameter int PS_W   = PRE_W + 3,
    parameter int COEF_W = 8,
    parameter logic [NUM_TERMS-1:0][COEF_W-1:0] COEFS = '0
) (
    input  logic [NUM_TERMS-1:0][PRE_W-1:0] terms,
    output logic [COEF_W-1:0][PS_W-1:0]     psum
);
    for (genvar b = 0; b < COEF_W; b++) begin : g_bit
        // Add the terms whose coefficient has a 1 in bit b.
        always_comb begin
            psum[b] = '0;
            for (int i = 0; i < NUM_TERMS; i++) begin
                if (COEFS[i][b])
                    psum[b] = psum[b]
                            + {{(PS_W-PRE_W){terms[i][PRE_W-1]}}, terms[i]};
            end
        end
    end
endmodule

// File: rtl/nd97_accum.sv
// Shift-right accumulator. Each step adds one partial sum, weighted by
// 2^(COEF_W-1), after shifting the running sum right by one. The last
// step negates its input, since the top bit has negative weight. After
// COEF_W steps the sum is exact, because no set bit is shifted out.
module nd97_accum #(
    parameter int PS_W   = 12,
    parameter int COEF_W = 8,
    parameter int ACC_W  = PS_W + COEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             last,
    input  logic [PS_W-1:0]  psel,
    output logic [ACC_W-1:0] acc_o
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] addend;

    // Sign-extend the partial sum, and negate it for the sign bit.
    always_comb begin
        ext    = {{(ACC_W-PS_W){psel[PS_W-1]}}, psel};
        addend = last ? (~ext + 1'b1) : ext;
    end

    // Running sum: shift right, then add the weighted partial sum.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (step) acc <= (acc >>> 1) + (addend <<< (COEF_W-1));
    end

    assign acc_o = acc;
endmodule

// File: rtl/nd97_lowpass.sv
// Top level: handshake, sequencer and bit-select multiplexer around the
// window, the adder array and the accumulator. One sample is taken in
// IDLE; LOAD shifts it into the window and clears the sum; RUN takes
// COEF_W bit steps, least significant first; DONE raises the valid pulse.
module nd97_lowpass
    import nd97_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter logic [NUM_TERMS-1:0][COEF_W-1:0] COEFS =
        {8'h03, 8'hFE, 8'hF6, 8'h22, 8'h4D},
    localparam int PRE_W = DATA_W + 1,
    localparam int PS_W  = PRE_W + $clog2(NUM_TERMS),
    localparam int ACC_W = PS_W + COEF_W,
    localparam int CNT_W = $clog2(COEF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              smp_ready,
    output logic              flt_valid,
    output logic [ACC_W-1:0]  flt_data
);
    seq_state_t                       state;
    logic [CNT_W-1:0]                 bit_cnt;
    logic                             accept;
    logic                             last_bit;
    logic [NUM_TERMS-1:0][PRE_W-1:0]  terms;
    logic [COEF_W-1:0][PS_W-1:0]      psum;
    logic [PS_W-1:0]                  psel;

    assign smp_ready = (state == ST_IDLE);
    assign accept    = smp_valid && smp_ready;
    assign last_bit  = (bit_cnt == CNT_W'(COEF_W-1));
    assign flt_valid = (state == ST_DONE);

    // Step through the phases of one computation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= ST_LOAD;
                ST_LOAD: begin
                    state   <= ST_RUN;
                    bit_cnt <= '0;
                end
                ST_RUN: begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pick the partial sum for the current bit.
    always_comb psel = psum[bit_cnt];

    nd97_tapline #(
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W)
    ) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (accept),
        .shift_en (state == ST_LOAD),
        .smp_data (smp_data),
        .terms    (terms)
    );

    nd97_bitsum #(
        .PRE_W  (PRE_W),
        .PS_W   (PS_W),
        .COEF_W (COEF_W),
        .COEFS  (COEFS)
    ) u_bitsum (
        .terms (terms),
        .psum  (psum)
    );

    nd97_accum #(
        .PS_W   (PS_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_LOAD),
        .step  (state == ST_RUN),
        .last  (last_bit),
        .psel  (psel),
        .acc_o (flt_data)
    );
endmodule

// File: rtl/nd97_lowpass_chk.sv
// Protocol and timing checks for nd97_lowpass, attached with bind.
// A cycle counter tracks the fixed latency from an accepted sample.
module nd97_lowpass_chk #(
    parameter int OUT_W = 20,
    parameter int LAT   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic             flt_valid,
    input logic [OUT_W-1:0] flt_data
);
    logic [7:0] lat;

    // Count cycles since the last accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                       lat <= '0;
        else if (smp_valid && smp_ready)  lat <= 8'd1;
        else if (lat != 0 && lat != LAT)  lat <= lat + 1'b1;
        else                              lat <= '0;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready); // R6
    AST_VALID_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> !smp_ready); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid); // R5
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid == (lat == 8'(LAT))); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && $past(smp_ready)) |-> $stable(flt_data)); // R10
endmodule

bind nd97_lowpass nd97_lowpass_chk #(.OUT_W(ACC_W), .LAT(COEF_W + 2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .flt_valid (flt_valid),
    .flt_data  (flt_data)
);

// File: tb/nd97_lowpass_test.sv
`timescale 1ns/1ps
module nd97_lowpass_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        smp_ready;
    logic        flt_valid;
    logic [19:0] flt_data;

    int checks = 0;
    int errors = 0;
    int win [9];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nd97_lowpass uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .flt_valid (flt_valid),
        .flt_data  (flt_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the weights 77, 34, -10, -2, 3.
    function automatic int ref_dot();
        return 77 * win[4] + 34 * (win[3] + win[5]) - 10 * (win[2] + win[6])
             - 2 * (win[1] + win[7]) + 3 * (win[0] + win[8]);
    endfunction

    function automatic int out_val();
        return int'($signed(flt_data));
    endfunction

    task automatic clear_win();
        for (int i = 0; i < 9; i++) win[i] = 0;
    endtask

    // Offer one sample, optionally keep poking while busy, check result.
    task automatic send(input int val, input bit poke, input string req);
        int n;
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = val[7:0];
        @(negedge clk);
        for (int i = 8; i > 0; i--) win[i] = win[i-1];
        win[0] = val;
        if (poke) smp_data = ~val[7:0];
        else      smp_valid = 1'b0;
        chk(!smp_ready, "R6 busy after accept", int'(smp_ready), 0);
        n = 0;
        while (!flt_valid && n < 30) begin
            @(negedge clk);
            n++;
            if (!flt_valid) chk(!smp_ready, "R6 ready low while busy", int'(smp_ready), 0);
        end
        smp_valid = 1'b0;
        chk(n == 9, "R5 latency", n, 9);
        chk(out_val() == ref_dot(), req, out_val(), ref_dot());
        @(negedge clk);
        chk(!flt_valid, "R5 single-cycle pulse", int'(flt_valid), 0);
        chk(smp_ready, "R1 ready after result", int'(smp_ready), 1);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int held;
        clear_win();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset.
        chk(smp_ready, "R1 ready after reset", int'(smp_ready), 1);
        chk(!flt_valid, "R1 no valid after reset", int'(flt_valid), 0);
        chk(out_val() == 0, "R1 output cleared", out_val(), 0);

        // R2/R3/R4: a unit impulse shows each weight in its window position.
        send(1, 1'b0, "R4 impulse at position 0");
        for (int k = 1; k < 9; k++) send(0, 1'b0, "R3 impulse walk");
        send(0, 1'b0, "R2 impulse leaves window");

        // R8: terms 1,2,3,4,5 give 122 (oldest sample first).
        clear_win();
        send(2, 1'b0, "R8 fill"); send(2, 1'b0, "R8 fill"); send(1, 1'b0, "R8 fill");
        send(1, 1'b0, "R8 fill"); send(1, 1'b0, "R8 fill"); send(1, 1'b0, "R8 fill");
        send(2, 1'b0, "R8 fill"); send(2, 1'b0, "R8 fill"); send(3, 1'b0, "R8 fill");
        chk(out_val() == 122, "R8 worked example", out_val(), 122);

        // R10: output held while idle.
        held = out_val();
        repeat (5) @(negedge clk);
        chk(out_val() == held, "R10 hold while idle", out_val(), held);

        // R4: every input value, with busy-time pokes (R6) on odd values.
        for (int v = -128; v < 128; v++) send(v, v[0], "R4 full value sweep");

        // R7: full-scale windows.
        for (int k = 0; k < 9; k++) send(-128, 1'b0, "R7 negative fill");
        chk(out_val() == -16256, "R7 full negative scale", out_val(), -16256);
        for (int k = 0; k < 9; k++) send(127, 1'b0, "R7 positive fill");
        chk(out_val() == 16129, "R7 full positive scale", out_val(), 16129);

        // R4/R6: pseudo-random stream.
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'($signed(lfsr[7:0])), lfsr[9], "R4 random stream");
        end

        // R9: reset in the middle of a computation.
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 8'd100;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_ready, "R9 ready after mid-run reset", int'(smp_ready), 1);
        chk(out_val() == 0, "R9 accumulator cleared", out_val(), 0);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(!flt_valid, "R9 no pulse after reset", int'(flt_valid), 0);
        end
        clear_win();
        send(5, 1'b0, "R9 window cleared");
        chk(out_val() == 15, "R9 only new sample present", out_val(), 15);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule